// File: doc/BRIEF.md
# Texel Waiting List Buffer

This block is the miss-tracking table of a non-blocking texture cache. Each texture request that has at least one missed texel takes one entry. An entry holds the request tag, the filter mode, and up to eight texel slots. Each slot has an address, a data word and a ready flag. The cache supplies the texels that hit when the request is allocated. The texels that missed are filled later, when a memory block returns and its block address matches a slot's texel address. One returning block updates every matching slot in every waiting entry in the same cycle. A slot that a later request shares with an earlier one therefore costs no second memory fetch to complete.

An entry whose needed slots are all ready is complete. The buffer offers one complete entry to the filtering stage through a valid/ready handshake, and the accepted entry is freed. When every entry is occupied, the buffer raises a full flag. The requester must stall while the flag is high, and an allocation attempted during that time is dropped. Requests leave in completion order, not arrival order. Restoring input order is left to a later stage.

Top module: `texel_wait_list`

## Requirements
- R1: After reset, no entry is occupied: `out_valid` is 0 and `full` is 0.
- R2: `alloc_mode` selects how many slots a request needs. Code 0 is nearest and uses slot 0 only. Code 1 is bilinear and uses slots 0 to 3. Codes 2 and 3 are trilinear and use all eight slots. Unused slots are ready from allocation, keep the data supplied with the allocation, and are never filled.
- R3: A slot whose bit is set in `alloc_hit` takes its `alloc_data` word and is ready at allocation. If every used slot hits, the request is offered on `out_valid` in the cycle after the allocation edge, with its tag, mode and data.
- R4: A texel address splits into a block address (the upper `ADDR_W-3` bits) and a word offset (the low 3 bits). On `fill_valid`, every not-ready slot of every occupied entry whose block address equals `fill_blk` takes word `offset` of `fill_words` (word k at bits k*DATA_W upward) and becomes ready. This happens for all entries at one clock edge.
- R5: A fill presented in the same cycle as an allocation also serves the missed slots of that allocation.
- R6: A fill never changes a slot that is already ready. Hit data survives a later fill of the same block.
- R7: An allocation takes the lowest-indexed free entry. When several entries are complete, the lowest-indexed one is offered.
- R8: While `out_valid` is high and `out_ready` is low, and no fill or allocation arrives, the offered tag and data stay unchanged. A handshake frees the entry.
- R9: `full` is high exactly when every entry is occupied. An allocation presented while `full` is high is ignored.
- R10: An entry with any used slot not yet ready is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new request this cycle |
| alloc_id | input | ID_W | Request tag |
| alloc_mode | input | 2 | Filter mode code (0 nearest, 1 bilinear, 2/3 trilinear) |
| alloc_addr | input | TEXELS*ADDR_W | Texel word addresses, slot t at bits t*ADDR_W |
| alloc_hit | input | TEXELS | Per-slot cache hit flags |
| alloc_data | input | TEXELS*DATA_W | Hit texel data, slot t at bits t*DATA_W |
| full | output | 1 | Every entry occupied; requester must stall |
| fill_valid | input | 1 | A memory block returns this cycle |
| fill_blk | input | ADDR_W-OFF_W | Block address of the returning block |
| fill_words | input | 2**OFF_W*DATA_W | Words of the returning block |
| out_valid | output | 1 | A complete entry is offered |
| out_ready | input | 1 | Filtering stage accepts the offered entry |
| out_id | output | ID_W | Tag of the offered entry |
| out_mode | output | 2 | Filter mode of the offered entry |
| out_data | output | TEXELS*DATA_W | Texel data of the offered entry |

## Verification
The fill path is driven with patterns that separate its cases. One block serves two entries whose slots sit at different offsets, which shows whether the offset selects the word per slot and whether all entries update in one edge. A block also covers slots that already hit, which shows whether ready slots are protected. A fill lands in the same cycle as its own allocation, which exposes a design that compares the fill only against stored entries. Each mode is tried with partial hit masks, so that a wrong used-slot count either completes a request early or never completes it. Completing a higher entry before a lower one, and stopping the output between fills, separates lowest-index selection from arrival order. A full table hit with an all-hit request shows whether the stall truly drops the request.

// File: rtl/twl_pkg.sv
package twl_pkg;

   typedef enum logic [1:0] {
      FM_NEAREST   = 2'd0,
      FM_BILINEAR  = 2'd1,
      FM_TRILINEAR = 2'd2,
      FM_TRI_ALT   = 2'd3
   } filt_mode_e;

   // number of leading texel slots a request of the given mode needs
   function automatic int used_slots(input filt_mode_e m, input int cap);
      case (m)
         FM_NEAREST:  return 1;
         FM_BILINEAR: return 4;
         default:     return cap;
      endcase
   endfunction

endpackage

// File: rtl/twl_lowest.sv
module twl_lowest #(
   parameter int N  = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
      gnt = any ? (N'(1) << idx) : '0;
   end
endmodule

// File: rtl/twl_entry.sv
module twl_entry #(
   parameter int TEXELS = 8,
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 3,
   parameter int DATA_W = 32,
   parameter int ID_W   = 8,
   localparam int BLK_W = ADDR_W - OFF_W,
   localparam int WORDS = 1 << OFF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ID_W-1:0]          load_id,
   input  logic [1:0]               load_mode,
   input  logic [TEXELS*ADDR_W-1:0] load_addr,
   input  logic [TEXELS*DATA_W-1:0] load_data,
   input  logic [TEXELS-1:0]        load_rdy,
   input  logic                     fill_valid,
   input  logic [BLK_W-1:0]         fill_blk,
   input  logic [WORDS*DATA_W-1:0]  fill_words,
   input  logic                     release_i,
   output logic                     valid_o,
   output logic                     done_o,
   output logic [ID_W-1:0]          id_o,
   output logic [1:0]               mode_o,
   output logic [TEXELS*DATA_W-1:0] data_o
);
   logic              valid_q;
   logic [ID_W-1:0]   id_q;
   logic [1:0]        mode_q;
   logic [TEXELS-1:0] rdy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         id_q    <= '0;
         mode_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         id_q    <= load_id;
         mode_q  <= load_mode;
      end else if (release_i) begin
         valid_q <= 1'b0;
      end
   end

   for (genvar t = 0; t < TEXELS; t++) begin : g_slot
      logic [ADDR_W-1:0] addr_q;
      logic [DATA_W-1:0] data_q;
      logic [ADDR_W-1:0] la;
      logic              hit_new, hit_old;
      logic [DATA_W-1:0] w_new, w_old;

      assign la      = load_addr[t*ADDR_W +: ADDR_W];
      assign hit_new = fill_valid && (la[ADDR_W-1:OFF_W] == fill_blk);
      assign hit_old = fill_valid && (addr_q[ADDR_W-1:OFF_W] == fill_blk);
      assign w_new   = fill_words[la[OFF_W-1:0] * DATA_W +: DATA_W];
      assign w_old   = fill_words[addr_q[OFF_W-1:0] * DATA_W +: DATA_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdy_q[t] <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
         end else if (load) begin
            addr_q   <= la;
            rdy_q[t] <= load_rdy[t] | hit_new;
            data_q   <= load_rdy[t] ? load_data[t*DATA_W +: DATA_W] : w_new;
         end else if (valid_q && !rdy_q[t] && hit_old) begin
            rdy_q[t] <= 1'b1;
            data_q   <= w_old;
         end
      end

      assign data_o[t*DATA_W +: DATA_W] = data_q;
   end

   assign valid_o = valid_q;
   assign done_o  = valid_q && (&rdy_q);
   assign id_o    = id_q;
   assign mode_o  = mode_q;
endmodule

// File: rtl/texel_wait_list.sv
module texel_wait_list #(
   parameter int ENTRIES = 32,
   parameter int TEXELS  = 8,
   parameter int ADDR_W  = 16,
   parameter int OFF_W   = 3,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 8,
   localparam int BLK_W  = ADDR_W - OFF_W,
   localparam int WORDS  = 1 << OFF_W,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid,
   input  logic [ID_W-1:0]          alloc_id,
   input  logic [1:0]               alloc_mode,
   input  logic [TEXELS*ADDR_W-1:0] alloc_addr,
   input  logic [TEXELS-1:0]        alloc_hit,
   input  logic [TEXELS*DATA_W-1:0] alloc_data,
   output logic                     full,
   input  logic                     fill_valid,
   input  logic [BLK_W-1:0]         fill_blk,
   input  logic [WORDS*DATA_W-1:0]  fill_words,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [ID_W-1:0]          out_id,
   output logic [1:0]               out_mode,
   output logic [TEXELS*DATA_W-1:0] out_data
);
   import twl_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("texel_wait_list: ENTRIES must be at least 2");
   end
   if (TEXELS < 4) begin : g_bad_texels
      $error("texel_wait_list: TEXELS must be at least 4");
   end
   if (OFF_W < 1 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("texel_wait_list: ADDR_W must exceed OFF_W >= 1");
   end

   logic [ENTRIES-1:0] valid_vec, done_vec, free_gnt, out_gnt, load_vec, rel_vec;
   logic [IW-1:0]      free_idx, sel_idx;
   logic               any_free;
   logic [TEXELS-1:0]  init_rdy;

   logic [ID_W-1:0]          e_id   [ENTRIES];
   logic [1:0]               e_mode [ENTRIES];
   logic [TEXELS*DATA_W-1:0] e_data [ENTRIES];

   for (genvar t = 0; t < TEXELS; t++) begin : g_init
      assign init_rdy[t] = alloc_hit[t] ||
                           (t >= used_slots(filt_mode_e'(alloc_mode), TEXELS));
   end

   twl_lowest #(.N(ENTRIES)) u_free (
      .req (~valid_vec),
      .gnt (free_gnt),
      .idx (free_idx),
      .any (any_free)
   );

   twl_lowest #(.N(ENTRIES)) u_done (
      .req (done_vec),
      .gnt (out_gnt),
      .idx (sel_idx),
      .any (out_valid)
   );

   assign full     = !any_free;
   assign load_vec = (alloc_valid && any_free) ? free_gnt : '0;
   assign rel_vec  = (out_valid && out_ready) ? out_gnt : '0;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      twl_entry #(
         .TEXELS (TEXELS),
         .ADDR_W (ADDR_W),
         .OFF_W  (OFF_W),
         .DATA_W (DATA_W),
         .ID_W   (ID_W)
      ) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load_vec[e]),
         .load_id    (alloc_id),
         .load_mode  (alloc_mode),
         .load_addr  (alloc_addr),
         .load_data  (alloc_data),
         .load_rdy   (init_rdy),
         .fill_valid (fill_valid),
         .fill_blk   (fill_blk),
         .fill_words (fill_words),
         .release_i  (rel_vec[e]),
         .valid_o    (valid_vec[e]),
         .done_o     (done_vec[e]),
         .id_o       (e_id[e]),
         .mode_o     (e_mode[e]),
         .data_o     (e_data[e])
      );
   end

   assign out_id   = e_id[sel_idx];
   assign out_mode = e_mode[sel_idx];
   assign out_data = e_data[sel_idx];

   logic unused_free_idx;
   assign unused_free_idx = ^free_idx;
endmodule

// File: rtl/texel_wait_list_chk.sv
module texel_wait_list_chk #(
   parameter int ENTRIES = 32,
   parameter int TEXELS  = 8,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 8,
   localparam int IW     = $clog2(ENTRIES)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     alloc_valid,
   input logic                     fill_valid,
   input logic                     full,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [ID_W-1:0]          out_id,
   input logic [TEXELS*DATA_W-1:0] out_data,
   input logic [ENTRIES-1:0]       valid_vec,
   input logic [ENTRIES-1:0]       done_vec,
   input logic [IW-1:0]            sel_idx
);
   // R1: state right after reset release is empty
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !full));

   // R7: nothing complete below the offered entry
   a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((done_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0));

   // R8: offer held while stalled and undisturbed
   a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !fill_valid && !alloc_valid)
      |=> (out_valid && $stable(out_id) && $stable(out_data)));

   // R9: a full table stays full until something leaves
   a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !(out_valid && out_ready)) |=> full);

   // R9: occupancy grows by at most one entry per cycle
   a_r9_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_vec) <= $past($countones(valid_vec)) + 1);

   // R10: only an occupied entry is offered
   a_r10_offer_occupied: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> valid_vec[sel_idx]);
endmodule

bind texel_wait_list texel_wait_list_chk #(
   .ENTRIES (ENTRIES),
   .TEXELS  (TEXELS),
   .DATA_W  (DATA_W),
   .ID_W    (ID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .fill_valid  (fill_valid),
   .full        (full),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_id      (out_id),
   .out_data    (out_data),
   .valid_vec   (valid_vec),
   .done_vec    (done_vec),
   .sel_idx     (sel_idx)
);

// File: tb/texel_wait_list_tb_top.sv
`timescale 1ns/1ps
module texel_wait_list_tb_top;
   localparam int ENTRIES = 32;
   localparam int TEXELS  = 8;
   localparam int ADDR_W  = 16;
   localparam int OFF_W   = 3;
   localparam int DATA_W  = 32;
   localparam int ID_W    = 8;
   localparam int BLK_W   = ADDR_W - OFF_W;
   localparam int WORDS   = 1 << OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic                     alloc_valid = 1'b0;
   logic [ID_W-1:0]          alloc_id = '0;
   logic [1:0]               alloc_mode = '0;
   logic [TEXELS*ADDR_W-1:0] alloc_addr = '0;
   logic [TEXELS-1:0]        alloc_hit = '0;
   logic [TEXELS*DATA_W-1:0] alloc_data = '0;
   logic                     full;
   logic                     fill_valid = 1'b0;
   logic [BLK_W-1:0]         fill_blk = '0;
   logic [WORDS*DATA_W-1:0]  fill_words = '0;
   logic                     out_valid;
   logic                     out_ready = 1'b0;
   logic [ID_W-1:0]          out_id;
   logic [1:0]               out_mode;
   logic [TEXELS*DATA_W-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   texel_wait_list #(
      .ENTRIES(ENTRIES), .TEXELS(TEXELS), .ADDR_W(ADDR_W),
      .OFF_W(OFF_W), .DATA_W(DATA_W), .ID_W(ID_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_id(alloc_id), .alloc_mode(alloc_mode),
      .alloc_addr(alloc_addr), .alloc_hit(alloc_hit), .alloc_data(alloc_data),
      .full(full),
      .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_words(fill_words),
      .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
      .out_mode(out_mode), .out_data(out_data)
   );

   function automatic logic [ADDR_W-1:0] ta(input int blk, input int off);
      return {blk[BLK_W-1:0], off[OFF_W-1:0]};
   endfunction

   function automatic logic [DATA_W-1:0] fw(input int blk, input int k);
      return 32'h5000_0000 + DATA_W'(blk * 16 + k);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // all tasks are entered at a falling edge and return at one
   task automatic do_alloc(input int id, input int mode,
                           input logic [TEXELS*ADDR_W-1:0] a,
                           input logic [TEXELS-1:0] hit,
                           input logic [TEXELS*DATA_W-1:0] d);
      alloc_valid = 1'b1;
      alloc_id    = ID_W'(id);
      alloc_mode  = 2'(mode);
      alloc_addr  = a;
      alloc_hit   = hit;
      alloc_data  = d;
      @(negedge clk);
      alloc_valid = 1'b0;
   endtask

   task automatic set_fill(input int blk);
      fill_valid = 1'b1;
      fill_blk   = BLK_W'(blk);
      for (int k = 0; k < WORDS; k++) fill_words[k*DATA_W +: DATA_W] = fw(blk, k);
   endtask

   task automatic do_fill(input int blk);
      set_fill(blk);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic expect_out(input string req, input int id,
                             input logic [TEXELS*DATA_W-1:0] d, input bit pop);
      check(req, "out_valid", 256'(out_valid), 256'(1));
      check(req, "out_id", 256'(out_id), 256'(id));
      check(req, "out_data", 256'(out_data), 256'(d));
      if (pop) begin
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
   endtask

   task automatic t_reset;
      check("R1", "out_valid", 256'(out_valid), 256'(0));
      check("R1", "full", 256'(full), 256'(0));
   endtask

   task automatic t_all_hit;
      logic [TEXELS*ADDR_W-1:0] a;
      logic [TEXELS*DATA_W-1:0] d;
      for (int i = 0; i < TEXELS; i++) begin
         a[i*ADDR_W +: ADDR_W] = ta(8, i);
         d[i*DATA_W +: DATA_W] = 32'h100 + DATA_W'(i);
      end
      do_alloc(5, 2, a, 8'hFF, d);
      check("R3", "out_mode", 256'(out_mode), 256'(2));
      expect_out("R3", 5, d, 1'b1);
      check("R8", "freed after handshake", 256'(out_valid), 256'(0));
   endtask

   task automatic t_modes;
      logic [TEXELS*ADDR_W-1:0] a;
      logic [TEXELS*DATA_W-1:0] d, e;
      for (int i = 0; i < TEXELS; i++) begin
         a[i*ADDR_W +: ADDR_W] = ta(1, i);
         d[i*DATA_W +: DATA_W] = 32'h1100_0000 + DATA_W'(i);
      end
      do_alloc(1, 0, a, 8'h01, d);
      expect_out("R2 nearest", 1, d, 1'b1);
      do_alloc(2, 1, a, 8'h0F, d);
      expect_out("R2 bilinear", 2, d, 1'b1);
      a[3*ADDR_W +: ADDR_W] = ta(16'h33, 5);
      a[5*ADDR_W +: ADDR_W] = ta(16'h33, 1);
      do_alloc(3, 1, a, 8'h07, d);
      check("R10", "incomplete not offered", 256'(out_valid), 256'(0));
      do_fill(16'h33);
      e = d;
      e[3*DATA_W +: DATA_W] = fw(16'h33, 5);
      expect_out("R2 unused slot untouched", 3, e, 1'b1);
   endtask

   task automatic t_fill_multi;
      logic [TEXELS*ADDR_W-1:0] a0, a1;
      logic [TEXELS*DATA_W-1:0] d0, d1, e0, e1;
      for (int i = 0; i < TEXELS; i++) begin
         a0[i*ADDR_W +: ADDR_W] = ta(16'h40, i);
         d0[i*DATA_W +: DATA_W] = 32'hB000 + DATA_W'(i);
         a1[i*ADDR_W +: ADDR_W] = ta(16'h40, 7 - i);
         d1[i*DATA_W +: DATA_W] = 32'hC000 + DATA_W'(i);
      end
      do_alloc(10, 2, a0, 8'hF0, d0);
      do_alloc(11, 1, a1, 8'h00, d1);
      check("R10", "missing slots hold both", 256'(out_valid), 256'(0));
      do_fill(16'h40);
      e0 = d0;
      e1 = d1;
      for (int i = 0; i < 4; i++) begin
         e0[i*DATA_W +: DATA_W] = fw(16'h40, i);
         e1[i*DATA_W +: DATA_W] = fw(16'h40, 7 - i);
      end
      expect_out("R6 R4 first entry", 10, e0, 1'b1);
      expect_out("R4 second entry same fill", 11, e1, 1'b1);
      check("R8", "empty after pops", 256'(out_valid), 256'(0));
   endtask

   task automatic t_same_cycle;
      logic [TEXELS*ADDR_W-1:0] a;
      logic [TEXELS*DATA_W-1:0] d, e;
      for (int i = 0; i < TEXELS; i++) begin
         a[i*ADDR_W +: ADDR_W] = ta(16'h55, 2);
         d[i*DATA_W +: DATA_W] = 32'hD000 + DATA_W'(i);
      end
      set_fill(16'h55);
      do_alloc(20, 0, a, 8'h00, d);
      fill_valid = 1'b0;
      e = d;
      e[0 +: DATA_W] = fw(16'h55, 2);
      expect_out("R5", 20, e, 1'b1);
   endtask

   task automatic t_order;
      logic [TEXELS*ADDR_W-1:0] a0, a1;
      logic [TEXELS*DATA_W-1:0] d, e0, e1;
      for (int i = 0; i < TEXELS; i++) begin
         a0[i*ADDR_W +: ADDR_W] = ta(16'h60, i);
         a1[i*ADDR_W +: ADDR_W] = ta(16'h61, 4);
         d[i*DATA_W +: DATA_W]  = 32'hE000 + DATA_W'(i);
      end
      do_alloc(30, 2, a0, 8'h00, d);
      do_alloc(31, 0, a1, 8'h00, d);
      do_fill(16'h61);
      e1 = d;
      e1[0 +: DATA_W] = fw(16'h61, 4);
      expect_out("R7 later entry completes first", 31, e1, 1'b0);
      repeat (3) @(negedge clk);
      expect_out("R8 held while stalled", 31, e1, 1'b0);
      do_fill(16'h60);
      for (int i = 0; i < TEXELS; i++) e0[i*DATA_W +: DATA_W] = fw(16'h60, i);
      expect_out("R7 lower index preferred", 30, e0, 1'b1);
      expect_out("R7 remaining entry", 31, e1, 1'b1);
   endtask

   task automatic t_full;
      logic [TEXELS*ADDR_W-1:0] a;
      logic [TEXELS*DATA_W-1:0] d, e;
      d = '0;
      for (int n = 0; n < ENTRIES; n++) begin
         a = '0;
         a[0 +: ADDR_W] = ta(16'h200 + n, n % WORDS);
         if (n == ENTRIES - 1) check("R9", "not full one short", 256'(full), 256'(0));
         do_alloc(n, 0, a, 8'h00, d);
      end
      check("R9", "full when all occupied", 256'(full), 256'(1));
      for (int i = 0; i < TEXELS; i++) a[i*ADDR_W +: ADDR_W] = ta(1, i);
      do_alloc(8'hEE, 2, a, 8'hFF, d);
      check("R9", "dropped request not offered", 256'(out_valid), 256'(0));
      for (int n = 0; n < ENTRIES; n++) begin
         do_fill(16'h200 + n);
         e = '0;
         e[0 +: DATA_W] = fw(16'h200 + n, n % WORDS);
         expect_out("R9 drain", n, e, 1'b1);
         if (n == 0) check("R9", "full clears after release", 256'(full), 256'(0));
      end
      check("R9", "ignored request never stored", 256'(out_valid), 256'(0));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_hit();
      t_modes();
      t_fill_multi();
      t_same_cycle();
      t_order();
      t_full();
      finish_run();
   end
endmodule